// File: doc/BRIEF.md
# Microcode Dispatch Sequencer

This unit computes the next micro-program counter for a microsequencer that branches through a lookup table. On an ordinary step the counter moves on by one. On a dispatch step the unit takes a bit field out of a data word in the same way a load-byte does. The field is found by a left-rotate count and a width. The unit ORs that field into a table base address and reads an entry from an internal dispatch table. Each entry carries its own control action and a target address, so one dispatch can jump, call, return, skip or do nothing. Each of these actions also behaves in a fixed way during the delay slot that the execute-next kinds open.

A 32-deep return-address stack serves calls and returns. When the save-own-address input is set, a call pushes the address of the dispatch step itself. When it is clear, a call pushes the address of the instruction that follows: one ahead for a plain call and two ahead for an execute-next call. The table is loaded through a separate write port. The micro-instruction store and the data path stay outside and appear only as ports.

The sequencing state machine has two states. `ST_RUN` is normal issue. `ST_SLOT` means the delay slot of an execute-next transfer is executing. There are two transitions. RUN goes to SLOT on a stepped dispatch whose entry is an execute-next kind. SLOT goes back to RUN on the next step, and that step loads the held target.

Top module: `udisp_seq`

## Requirements
- R1: After reset, `upc` is 0, `stk_err` is 0, the stack is empty and the unit is in `ST_RUN`.
- R2: A step with `is_disp` low in `ST_RUN` advances `upc` by one. A cycle with `step` low leaves `upc` and the sequencing state unchanged.
- R3: The table index is built as follows. Rotate `data_word` left by `rot`. Keep its low `fld_width` bits, where a width above 11 is treated as 11. Bitwise-OR that field with `tbl_base`; it is never added.
- R4: When `xsel_en` is high, bit `xsrc[xsel]` is ORed into bit 0 of the table index. When `xsel_en` is low, no extra bit is added.
- R5: An entry is 17 bits: bits 16..14 hold the action and bits 13..0 hold the target. The action codes are 0 no-op, 1 jump, 2 jump-execute-next, 3 call, 4 call-execute-next, 5 return, 6 skip and 7 reserved (acts as no-op). A jump loads the target into `upc`.
- R6: An execute-next jump or call first sets `upc` to the dispatch address plus one. On the next step it loads the target. During that slot step, `is_disp` is ignored.
- R7: With `save_own` low, a call pushes the dispatch address plus one and an execute-next call pushes the dispatch address plus two.
- R8: With `save_own` high, any call pushes the address of the dispatch step itself.
- R9: A return pops the stack and loads the popped address into `upc`.
- R10: A skip sets `upc` to the dispatch address plus two and leaves the stack alone. A no-op or the reserved code sets it to the dispatch address plus one.
- R11: A push onto a full stack (32 entries) and a pop of an empty stack both set the sticky `stk_err` and leave the stack unchanged. A call onto a full stack still jumps. A return from an empty stack continues at the dispatch address plus one.
- R12: A table write on `tbl_we` changes the entry used by every later dispatch to that index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 1 | One microinstruction issues this cycle |
| is_disp | input | 1 | The issuing microinstruction is a dispatch |
| save_own | input | 1 | A call pushes the dispatch step's own address |
| data_word | input | 32 | Word that the field is taken from |
| rot | input | 5 | Left-rotate count for the field |
| fld_width | input | 4 | Field width in bits (0 to 11) |
| tbl_base | input | 11 | Table base address from the instruction |
| xsel_en | input | 1 | Enable the extra select bit |
| xsel | input | 2 | Chooses which external bit is the extra select |
| xsrc | input | 4 | External status bits that can be chosen |
| tbl_we | input | 1 | Table write strobe |
| tbl_waddr | input | 11 | Table write index |
| tbl_wdata | input | 17 | Table write entry |
| upc | output | 14 | Current micro-program counter |
| stk_err | output | 1 | Sticky stack overflow or underflow flag |

## Verification
A wrong index, action decode or pushed address shows up at `upc` on the first clock edge after the dispatch step. A wrong stack pointer or a lost entry only shows later, when a return lands somewhere other than the model's popped address. For that reason the bench fills the stack to capacity, overflows it, and drains it completely. A slot state that sticks or gets skipped shows up as a missing or extra `+1` step one cycle after an execute-next transfer.

// File: rtl/udisp_pkg.sv
package udisp_pkg;
    typedef enum logic [2:0] {
        ACT_NOP   = 3'd0,
        ACT_JMP   = 3'd1,
        ACT_JMPX  = 3'd2,
        ACT_CALL  = 3'd3,
        ACT_CALLX = 3'd4,
        ACT_RET   = 3'd5,
        ACT_SKIP  = 3'd6,
        ACT_RSV   = 3'd7
    } act_e;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_SLOT = 1'b1
    } st_e;
endpackage

// File: rtl/udisp_field.sv
module udisp_field #(
    parameter int DW = 32,
    parameter int IW = 11,
    parameter int XN = 4,
    localparam int RW = $clog2(DW),
    localparam int WW = $clog2(IW + 1),
    localparam int XS = $clog2(XN)
) (
    input  logic [DW-1:0] data_word,
    input  logic [RW-1:0] rot,
    input  logic [WW-1:0] fld_width,
    input  logic [IW-1:0] tbl_base,
    input  logic          xsel_en,
    input  logic [XS-1:0] xsel,
    input  logic [XN-1:0] xsrc,
    output logic [IW-1:0] idx
);
    logic [2*DW-1:0] dbl;
    logic [DW-1:0]   rotated;
    logic [WW-1:0]   wsat;
    logic [IW:0]     mask;
    logic [IW-1:0]   extra;

    always_comb begin
        dbl     = {data_word, data_word} << rot;
        rotated = dbl[2*DW-1:DW];
        wsat    = (fld_width > WW'(IW)) ? WW'(IW) : fld_width;
        mask    = ((IW+1)'(1) << wsat) - (IW+1)'(1);
        extra   = {{(IW-1){1'b0}}, xsel_en & xsrc[xsel]};
        idx     = (rotated[IW-1:0] & mask[IW-1:0]) | tbl_base | extra;
    end
endmodule

// File: rtl/udisp_table.sv
module udisp_table #(
    parameter int IW = 11,
    parameter int EW = 17,
    localparam int N = 1 << IW
) (
    input  logic          clk,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  logic [EW-1:0] wdata,
    input  logic [IW-1:0] raddr,
    output logic [EW-1:0] rdata
);
    logic [EW-1:0] mem [N];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/udisp_stack.sv
module udisp_stack #(
    parameter int DEPTH = 32,
    parameter int AW = 14,
    localparam int LW = $clog2(DEPTH),
    localparam int PW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [AW-1:0] din,
    output logic [AW-1:0] dout,
    output logic          empty,
    output logic          err,
    output logic [PW-1:0] depth
);
    logic [AW-1:0] mem [DEPTH];
    logic [PW-1:0] sp;
    logic [PW-1:0] sp_m1;
    logic          full;

    assign full  = (sp == PW'(DEPTH));
    assign empty = (sp == '0);
    assign sp_m1 = sp - PW'(1);
    assign dout  = empty ? '0 : mem[sp_m1[LW-1:0]];
    assign depth = sp;

    always_ff @(posedge clk) begin
        if (push && !full) mem[sp[LW-1:0]] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp  <= '0;
            err <= 1'b0;
        end else if (push) begin
            if (full) err <= 1'b1;
            else      sp  <= sp + PW'(1);
        end else if (pop) begin
            if (empty) err <= 1'b1;
            else       sp  <= sp_m1;
        end
    end
endmodule

// File: rtl/udisp_seq.sv
module udisp_seq
    import udisp_pkg::*;
#(
    parameter int DW = 32,
    parameter int IW = 11,
    parameter int AW = 14,
    parameter int DEPTH = 32,
    parameter int XN = 4,
    localparam int RW = $clog2(DW),
    localparam int WW = $clog2(IW + 1),
    localparam int XS = $clog2(XN),
    localparam int EW = 3 + AW,
    localparam int SPW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          is_disp,
    input  logic          save_own,
    input  logic [DW-1:0] data_word,
    input  logic [RW-1:0] rot,
    input  logic [WW-1:0] fld_width,
    input  logic [IW-1:0] tbl_base,
    input  logic          xsel_en,
    input  logic [XS-1:0] xsel,
    input  logic [XN-1:0] xsrc,
    input  logic          tbl_we,
    input  logic [IW-1:0] tbl_waddr,
    input  logic [EW-1:0] tbl_wdata,
    output logic [AW-1:0] upc,
    output logic          stk_err
);
    st_e           st, nxt_st;
    logic [AW-1:0] tgt, nxt_tgt, nxt_upc;
    logic [IW-1:0] idx;
    logic [EW-1:0] ent;
    act_e          act;
    logic [AW-1:0] etgt;
    logic          push, pop, stk_empty;
    logic [AW-1:0] push_val, stk_top;
    logic [SPW-1:0] stk_depth;
    logic          in_slot;

    udisp_field #(.DW(DW), .IW(IW), .XN(XN)) field_i (
        .data_word(data_word), .rot(rot), .fld_width(fld_width),
        .tbl_base(tbl_base), .xsel_en(xsel_en), .xsel(xsel),
        .xsrc(xsrc), .idx(idx)
    );

    udisp_table #(.IW(IW), .EW(EW)) table_i (
        .clk(clk), .we(tbl_we), .waddr(tbl_waddr), .wdata(tbl_wdata),
        .raddr(idx), .rdata(ent)
    );

    udisp_stack #(.DEPTH(DEPTH), .AW(AW)) stack_i (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
        .din(push_val), .dout(stk_top), .empty(stk_empty),
        .err(stk_err), .depth(stk_depth)
    );

    assign act     = act_e'(ent[EW-1:AW]);
    assign etgt    = ent[AW-1:0];
    assign in_slot = (st == ST_SLOT);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= ST_RUN;
            upc <= '0;
            tgt <= '0;
        end else begin
            st  <= nxt_st;
            upc <= nxt_upc;
            tgt <= nxt_tgt;
        end
    end

    // Next-state and outputs
    always_comb begin
        nxt_st   = st;
        nxt_upc  = upc;
        nxt_tgt  = tgt;
        push     = 1'b0;
        pop      = 1'b0;
        push_val = '0;
        if (step) begin
            unique case (st)
                ST_SLOT: begin
                    nxt_upc = tgt;
                    nxt_st  = ST_RUN;
                end
                ST_RUN: begin
                    if (!is_disp) begin
                        nxt_upc = upc + AW'(1);
                    end else begin
                        unique case (act)
                            ACT_JMP: nxt_upc = etgt;
                            ACT_JMPX: begin
                                nxt_upc = upc + AW'(1);
                                nxt_tgt = etgt;
                                nxt_st  = ST_SLOT;
                            end
                            ACT_CALL: begin
                                push     = 1'b1;
                                push_val = save_own ? upc : upc + AW'(1);
                                nxt_upc  = etgt;
                            end
                            ACT_CALLX: begin
                                push     = 1'b1;
                                push_val = save_own ? upc : upc + AW'(2);
                                nxt_upc  = upc + AW'(1);
                                nxt_tgt  = etgt;
                                nxt_st   = ST_SLOT;
                            end
                            ACT_RET: begin
                                pop     = 1'b1;
                                nxt_upc = stk_empty ? upc + AW'(1) : stk_top;
                            end
                            ACT_SKIP: nxt_upc = upc + AW'(2);
                            default:  nxt_upc = upc + AW'(1);
                        endcase
                    end
                end
                default: nxt_st = ST_RUN;
            endcase
        end
    end
endmodule

// File: rtl/udisp_seq_chk.sv
module udisp_seq_chk #(
    parameter int AW = 14,
    parameter int PW = 6,
    parameter int DEPTH = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          step,
    input logic          is_disp,
    input logic          in_slot,
    input logic [AW-1:0] upc,
    input logic          stk_err,
    input logic [PW-1:0] depth
);
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> ($stable(upc) && $stable(in_slot)));

    p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !is_disp && !in_slot) |=> (upc == $past(upc) + AW'(1)));

    p_slot_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && in_slot) |=> !in_slot);

    p_slot_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_slot) |-> (upc == $past(upc) + AW'(1)));

    p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        stk_err |=> stk_err);

    p_depth_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
        depth <= PW'(DEPTH));
endmodule

bind udisp_seq udisp_seq_chk #(.AW(AW), .PW(SPW), .DEPTH(DEPTH)) chk_i (
    .clk(clk), .rst_n(rst_n), .step(step), .is_disp(is_disp),
    .in_slot(in_slot), .upc(upc), .stk_err(stk_err), .depth(stk_depth)
);

// File: tb/udisp_seq_tb.sv
`timescale 1ns/1ps
module udisp_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step = 1'b0, is_disp = 1'b0, save_own = 1'b0;
    logic [31:0] data_word = '0;
    logic [4:0]  rot = '0;
    logic [3:0]  fld_width = '0;
    logic [10:0] tbl_base = '0;
    logic        xsel_en = 1'b0;
    logic [1:0]  xsel = '0;
    logic [3:0]  xsrc = '0;
    logic        tbl_we = 1'b0;
    logic [10:0] tbl_waddr = '0;
    logic [16:0] tbl_wdata = '0;
    logic [13:0] upc;
    logic        stk_err;

    int checks = 0, errors = 0;
    bit done = 0;

    udisp_seq dut_i (.*);

    always #5 clk = ~clk;

    // reference model state
    logic [13:0] mu;
    bit          merr, mslot;
    logic [13:0] mtgt;
    logic [13:0] mstk[$];
    logic [16:0] tab [int];

    // scoreboard
    logic [13:0] q_upc[$];
    bit          q_err[$];
    string       q_tag[$];

    always @(negedge clk) begin
        while (q_upc.size() > 0) begin
            logic [13:0] eu;
            bit ee;
            string t;
            eu = q_upc.pop_front();
            ee = q_err.pop_front();
            t  = q_tag.pop_front();
            checks++;
            if (upc !== eu || stk_err !== ee) begin
                errors++;
                $display("FAIL %s: upc=%h err=%0b expected upc=%h err=%0b",
                         t, upc, stk_err, eu, ee);
            end
        end
    end

    task automatic expect_now(string tag);
        q_upc.push_back(mu);
        q_err.push_back(merr);
        q_tag.push_back(tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        step = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        mu = '0; merr = 0; mslot = 0; mtgt = '0;
        mstk.delete();
        expect_now("R1 reset state");
    endtask

    task automatic wr_tab(input logic [10:0] a, input logic [2:0] act,
                          input logic [13:0] t);
        @(negedge clk);
        tbl_we = 1'b1; tbl_waddr = a; tbl_wdata = {act, t};
        @(posedge clk);
        #1 tbl_we = 1'b0;
        tab[int'(a)] = {act, t};
    endtask

    function automatic logic [10:0] ref_idx(logic [31:0] d, logic [4:0] r,
            logic [3:0] w, logic [10:0] b, bit xe, logic [1:0] xs, logic [3:0] xv);
        logic [10:0] f = '0;
        int wl = (w > 11) ? 11 : int'(w);
        for (int i = 0; i < wl; i++) f[i] = d[(i - int'(r) + 32) % 32];
        f = f | b;
        if (xe) f[0] = f[0] | xv[xs];
        return f;
    endfunction

    task automatic model_push(logic [13:0] v);
        if (mstk.size() == 32) merr = 1;
        else mstk.push_back(v);
    endtask

    task automatic stp(bit isd, bit so, logic [31:0] d, logic [4:0] r,
                       logic [3:0] w, logic [10:0] b, bit xe, logic [1:0] xs,
                       logic [3:0] xv, string tag);
        @(negedge clk);
        step = 1'b1; is_disp = isd; save_own = so; data_word = d; rot = r;
        fld_width = w; tbl_base = b; xsel_en = xe; xsel = xs; xsrc = xv;
        if (mslot) begin
            mu = mtgt; mslot = 0;
        end else if (!isd) begin
            mu = mu + 14'd1;
        end else begin
            logic [16:0] e;
            e = tab[int'(ref_idx(d, r, w, b, xe, xs, xv))];
            case (e[16:14])
                3'd1: mu = e[13:0];
                3'd2: begin mtgt = e[13:0]; mslot = 1; mu = mu + 14'd1; end
                3'd3: begin model_push(so ? mu : mu + 14'd1); mu = e[13:0]; end
                3'd4: begin model_push(so ? mu : mu + 14'd2); mtgt = e[13:0];
                            mslot = 1; mu = mu + 14'd1; end
                3'd5: begin
                    if (mstk.size() == 0) begin merr = 1; mu = mu + 14'd1; end
                    else mu = mstk.pop_back();
                end
                3'd6: mu = mu + 14'd2;
                default: mu = mu + 14'd1;
            endcase
        end
        @(posedge clk);
        #1 step = 1'b0; is_disp = 1'b0;
        expect_now(tag);
    endtask

    task automatic seq(string tag);
        stp(0, 0, '0, '0, '0, '0, 0, '0, '0, tag);
    endtask

    task automatic dsp(bit so, logic [10:0] b, logic [31:0] d, logic [4:0] r,
                       logic [3:0] w, string tag);
        stp(1, so, d, r, w, b, 0, '0, '0, tag);
    endtask

    task automatic idle(string tag);
        @(negedge clk);
        step = 1'b0; is_disp = 1'b1; data_word = 32'h0000_0005; tbl_base = 11'h100;
        @(posedge clk);
        #1 is_disp = 1'b0;
        expect_now(tag);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        // entries (action: 0 nop 1 jmp 2 jmpx 3 call 4 callx 5 ret 6 skip 7 rsv)
        wr_tab(11'h105, 3'd1, 14'h0200);
        wr_tab(11'h10A, 3'd1, 14'h0300);
        wr_tab(11'h123, 3'd1, 14'h0310);
        wr_tab(11'h101, 3'd1, 14'h0400);
        wr_tab(11'h102, 3'd1, 14'h3BAD);
        wr_tab(11'h140, 3'd1, 14'h0440);
        wr_tab(11'h141, 3'd1, 14'h0441);
        wr_tab(11'h200, 3'd2, 14'h0500);
        wr_tab(11'h201, 3'd3, 14'h0600);
        wr_tab(11'h202, 3'd4, 14'h0700);
        wr_tab(11'h203, 3'd5, 14'h0000);
        wr_tab(11'h204, 3'd6, 14'h0000);
        wr_tab(11'h205, 3'd0, 14'h1111);
        wr_tab(11'h206, 3'd7, 14'h2222);
        idle("R2 table writes without step hold upc");

        seq("R2 sequential step");
        seq("R2 sequential step");
        idle("R2 no step holds upc");
        dsp(0, 11'h100, 32'h0000_0005, 5'd0, 4'd3, "R3 R5 jump via field 5");
        dsp(0, 11'h100, 32'hA000_0000, 5'd4, 4'd4, "R3 rotate left by 4");
        dsp(0, 11'h120, 32'h0000_00FF, 5'd0, 4'd2, "R3 width masks field");
        dsp(0, 11'h101, 32'h0000_0001, 5'd0, 4'd1, "R3 field ORed not added");
        stp(1, 0, '0, '0, '0, 11'h140, 1, 2'd2, 4'b0100, "R4 extra select bit set");
        stp(1, 0, '0, '0, '0, 11'h140, 1, 2'd2, 4'b1011, "R4 chosen bit clear");
        stp(1, 0, '0, '0, '0, 11'h140, 0, 2'd0, 4'b1111, "R4 extra select disabled");

        dsp(0, 11'h200, '0, '0, '0, "R6 jump-xn runs slot");
        dsp(0, 11'h205, '0, '0, '0, "R6 dispatch ignored in slot, target taken");
        dsp(0, 11'h201, '0, '0, '0, "R7 call");
        seq("R7 body step");
        dsp(0, 11'h203, '0, '0, '0, "R7 R9 return to call+1");
        dsp(0, 11'h202, '0, '0, '0, "R7 call-xn runs slot");
        seq("R7 call-xn target");
        dsp(0, 11'h203, '0, '0, '0, "R7 R9 return to call+2");
        dsp(1, 11'h201, '0, '0, '0, "R8 save-own call");
        dsp(0, 11'h203, '0, '0, '0, "R8 return to own address");
        dsp(1, 11'h202, '0, '0, '0, "R8 save-own call-xn");
        seq("R8 call-xn target");
        dsp(0, 11'h203, '0, '0, '0, "R8 return to own address after xn");
        dsp(0, 11'h204, '0, '0, '0, "R10 skip by two");
        dsp(0, 11'h205, '0, '0, '0, "R10 no-op by one");
        dsp(0, 11'h206, '0, '0, '0, "R10 reserved acts as no-op");

        wr_tab(11'h105, 3'd6, 14'h0000);
        dsp(0, 11'h100, 32'h0000_0005, 5'd0, 4'd3, "R12 rewritten entry now skips");

        dsp(0, 11'h203, '0, '0, '0, "R11 underflow sets error");
        seq("R11 error sticky");

        do_reset();
        for (int i = 0; i < 33; i++) begin
            dsp(0, 11'h201, '0, '0, '0, "R11 fill stack with calls");
            seq("R11 step between calls");
        end
        for (int i = 0; i < 33; i++) begin
            dsp(0, 11'h203, '0, '0, '0, "R11 drain after overflow");
        end
        repeat (3) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule